// File: doc/BRIEF.md
# Quarter-Rate Multiplierless Complex Downconverter

This block moves the band centred at one quarter of the input sample rate down to zero frequency, then halves the rate and produces separate in-phase and quadrature streams. The real input arrives as two consecutive samples per clock: the even-numbered sample and then the odd-numbered one. When the input runs at 256 MSPS, the 64 MHz component is shifted to DC, and each output stream runs at 128 MSPS.

The mixing multiplies the samples by a repeating rotation of +1, +j, -1, -j. Every product is therefore the sample itself, its negation, or a move between the real and imaginary paths, and the block contains no multipliers. Because the rate drops by two, the even sample of each pair becomes I and the odd sample becomes Q. Both take a common sign that flips on each accepted pair. No filter stage follows, so each output is one word per clock under a valid flag, ready for two separate downstream ports.

Top module: `quarter_rate_ddc`

## Requirements
- R1: For the m-th accepted input pair after reset (m counted from 0), out_i equals in_even times s and out_q equals in_odd times s. The sign s is +1 when m is even and -1 when m is odd.
- R2: The sign applied to the outputs alternates on every accepted pair (in_valid high), starting with +1 on the first pair after reset.
- R3: Negation saturates. A negated input of the most negative value (-32768 at the default 16-bit width) gives the most positive value (32767) and never wraps.
- R4: out_valid equals in_valid from the previous clock. The out_i and out_q results for a pair appear on the clock after that pair is accepted.
- R5: While rst is high, out_valid, out_i and out_q are 0, and the first pair accepted after rst falls is treated as m = 0.
- R6: A clock with in_valid low does not advance the sign sequence, and out_i and out_q keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pair valid |
| in_even | input | W (16) | Earlier real sample of the pair, two's complement |
| in_odd | input | W (16) | Later real sample of the pair, two's complement |
| out_valid | output | 1 | Output sample valid |
| out_i | output | W (16) | In-phase output, two's complement |
| out_q | output | W (16) | Quadrature output, two's complement |

## Verification
The hardest case to reach from the ports is the saturating negation. It needs the most negative input to arrive on a pair whose rotation sign is negative, and that sign depends on how many valid pairs came before, with idle clocks in between not counting. The stimulus therefore sends a counted run of pairs with in_valid gaps placed in it, so that the extreme value lands on an odd pair index in both lanes and also on an even index for comparison. The bench keeps its own pair counter to predict the sign.

// File: rtl/dcq_pkg.sv
package dcq_pkg;
  localparam int unsigned LANES = 2;
  typedef enum logic [0:0] {LANE_I = 1'b0, LANE_Q = 1'b1} lane_e;
endpackage

// File: rtl/dcq_phase.sv
module dcq_phase (
  input  logic clk,
  input  logic rst,
  input  logic advance,
  output logic neg
);
  always_ff @(posedge clk) begin
    if (rst)          neg <= 1'b0;
    else if (advance) neg <= ~neg;
  end
endmodule

// File: rtl/dcq_satneg.sv
module dcq_satneg #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] din,
  input  logic         neg,
  output logic [W-1:0] dout
);
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAXV = ~MINV;
  always_comb begin
    if (!neg)             dout = din;
    else if (din == MINV) dout = MAXV;
    else                  dout = ~din + 1'b1;
  end
endmodule

// File: rtl/dcq_lane.sv
module dcq_lane #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         neg,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] mixed;
  dcq_satneg #(.W(W)) u_neg (.din(din), .neg(neg), .dout(mixed));
  always_ff @(posedge clk) begin
    if (rst)       dout <= '0;
    else if (load) dout <= mixed;
  end
endmodule

// File: rtl/quarter_rate_ddc.sv
module quarter_rate_ddc #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_even,
  input  logic [W-1:0] in_odd,
  output logic         out_valid,
  output logic [W-1:0] out_i,
  output logic [W-1:0] out_q
);
  import dcq_pkg::*;
  logic         rot_neg;
  logic [W-1:0] lane_in  [LANES];
  logic [W-1:0] lane_out [LANES];

  dcq_phase u_phase (.clk(clk), .rst(rst), .advance(in_valid), .neg(rot_neg));

  assign lane_in[LANE_I] = in_even;
  assign lane_in[LANE_Q] = in_odd;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dcq_lane #(.W(W)) u_lane (
      .clk(clk), .rst(rst), .load(in_valid), .neg(rot_neg),
      .din(lane_in[g]), .dout(lane_out[g])
    );
  end

  assign out_i = lane_out[LANE_I];
  assign out_q = lane_out[LANE_Q];

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end
endmodule

// File: rtl/dcq_checker.sv
module dcq_checker #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] in_even,
  input logic [W-1:0] in_odd,
  input logic         out_valid,
  input logic [W-1:0] out_i,
  input logic [W-1:0] out_q,
  input logic         rot_neg
);
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAXV = ~MINV;

  AST_PASS_POSITIVE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !rot_neg) |=> (out_i == $past(in_even) && out_q == $past(in_odd))); // R1
  AST_SIGN_FLIP: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (rot_neg != $past(rot_neg))); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rot_neg && in_even == MINV) |=> (out_i == MAXV)); // R3
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R4
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R4
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && out_i == '0 && out_q == '0 && !rot_neg)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_i) && $stable(out_q) && $stable(rot_neg))); // R6
endmodule

bind quarter_rate_ddc dcq_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_even(in_even), .in_odd(in_odd),
  .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .rot_neg(rot_neg)
);

// File: tb/tb_quarter_rate_ddc.sv
module tb_quarter_rate_ddc;
  localparam int W = 16;
  localparam logic [W-1:0] MINV = 16'h8000;
  localparam logic [W-1:0] MAXV = 16'h7FFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [W-1:0] in_even = '0, in_odd = '0;
  logic out_valid;
  logic [W-1:0] out_i, out_q;

  int checks = 0, fails = 0, pair_m = 0;
  logic [W-1:0] exp_i = '0, exp_q = '0;

  always #5 clk = ~clk;

  quarter_rate_ddc #(.W(W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_even(in_even), .in_odd(in_odd),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  function automatic logic [W-1:0] mix(input logic [W-1:0] x, input bit negate);
    if (!negate) return x;
    if (x == MINV) return MAXV;
    return -x;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, check at following negedge
  task automatic step(input bit v, input logic [W-1:0] e, input logic [W-1:0] o, input string req);
    in_valid = v; in_even = e; in_odd = o;
    if (v) begin
      exp_i = mix(e, pair_m[0]);
      exp_q = mix(o, pair_m[0]);
      pair_m++;
    end
    @(negedge clk);
    check({req, " valid"}, {15'd0, out_valid}, {15'd0, v});
    check({req, " i"}, out_i, exp_i);
    check({req, " q"}, out_q, exp_q);
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    // R5: cleared while in reset
    check("R5 valid", {15'd0, out_valid}, 16'd0);
    check("R5 i", out_i, '0);
    check("R5 q", out_q, '0);
    rst = 1'b0; pair_m = 0; exp_i = '0; exp_q = '0;
  endtask

  task automatic t_ramp(); // R1 R2 R4
    for (int k = 0; k < 8; k++) step(1'b1, W'(100 + 2*k), W'(101 + 2*k), "R1");
  endtask

  task automatic t_gaps(); // R6 R2
    step(1'b1, 16'd500, 16'hFFF0, "R2");
    step(1'b0, 16'd9, 16'd9, "R6");
    step(1'b0, 16'd7, 16'd7, "R6");
    step(1'b1, 16'd600, 16'd3, "R6");
    step(1'b0, 16'd1, 16'd1, "R4");
    step(1'b1, 16'd700, 16'd4, "R2");
  endtask

  task automatic t_extreme(); // R3
    if (pair_m[0] == 1'b0) step(1'b1, 16'd1, 16'd2, "R3");
    step(1'b1, MINV, MINV, "R3");
    step(1'b0, 16'd0, 16'd0, "R3");
    step(1'b1, MINV, MAXV, "R3");
    step(1'b1, MAXV, MINV, "R3");
  endtask

  task automatic t_reset_restart(); // R5
    step(1'b1, 16'd11, 16'd12, "R5");
    do_reset();
    step(1'b1, 16'd21, 16'hFFFF, "R5");
    step(1'b1, 16'd21, 16'hFFFF, "R5");
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    join_none
    @(negedge clk);
    do_reset();
    t_ramp();
    t_gaps();
    t_extreme();
    t_reset_restart();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule